// File: doc/BRIEF.md
# Decimating FIR Coefficient Address Sequencer

This block drives the coefficient side of a decimating FIR stage whose coefficients live in one 256-word memory shared by several filters. It counts accepted input samples. When an output is due it walks the filter's taps, giving one coefficient read address per cycle. The address starts from a base pointer that is double-buffered. Each read carries strobes that mark the first and last tap of the output.

A small host register port sets the decimation, the tap count, the start phase, the base pointer and a control word. The control word can bypass the filter, take samples from a neighbouring channel, and choose which half of the memory the host's 7-bit coefficient writes reach. The multiply-accumulate datapath and the memory itself sit outside the block.

Top module: `coef_addr_seq`

## Requirements
- R1: After reset, rd_valid, first_tap, last_tap and overrun are 0. No sample is counted until the first start pulse.
- R2: Register select 0 holds the decimation minus one (M-1). With phase 0, one output walk is requested on every M-th counted sample after start.
- R3: Register select 2 (phase P) is loaded into the sample counter on start, so the first walk follows M-P counted samples. A phase write takes effect only at the next start.
- R4: Register select 1 holds the tap count minus one (N-1). Each walk issues N reads on consecutive cycles. The first read appears in the cycle after the clock edge that counted the triggering sample.
- R5: rd_addr equals the active base pointer plus the tap index, modulo 256, and rises by one on each read.
- R6: first_tap is high on tap 0 and last_tap is high on tap N-1. Both are high on the same read when N is 1.
- R7: Register select 3 writes a shadow base pointer. It is copied into the active pointer when a walk begins, so a write during a walk affects only the next output.
- R8: A request that arrives while a walk is on a tap other than its last is dropped, and overrun pulses for one cycle after that edge. A request on the last-tap cycle starts the next walk in the following cycle with no gap.
- R9: Register select 4 bit 0 (bypass) stops sample counting and coefficient reads. While it is set, byp_valid follows the selected sample strobe in the same cycle.
- R10: Register select 4 bit 1 chooses the sample strobe that is counted: own_valid when 0, nbr_valid when 1.
- R11: A coefficient write gives mem_we = cw_we, mem_waddr = {register select 4 bit 2, cw_addr} and mem_wdata = cw_data, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select (0 decim, 1 taps, 2 phase, 3 base, 4 control) |
| reg_wdata | input | 8 | Register write data |
| start | input | 1 | Filter start: loads phase into the sample counter |
| own_valid | input | 1 | Own-channel sample strobe |
| nbr_valid | input | 1 | Neighbour-channel sample strobe |
| cw_we | input | 1 | Host coefficient write strobe |
| cw_addr | input | 7 | Coefficient word address within a half |
| cw_data | input | 16 | Coefficient write data |
| rd_valid | output | 1 | Coefficient read address valid |
| rd_addr | output | 8 | Coefficient read address |
| first_tap | output | 1 | Read is tap 0 of an output |
| last_tap | output | 1 | Read is the final tap of an output |
| overrun | output | 1 | One-cycle pulse: request dropped during a walk |
| byp_valid | output | 1 | Bypassed sample strobe |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | 8 | Memory write address |
| mem_wdata | output | 16 | Memory write data |

## Verification
A new output request and the last tap of the current walk can fall in the same cycle. So can a request and a tap in the middle of a walk. With a decimation of one, the bench sends samples either on every cycle or on every second cycle, so that a request lands on a middle tap in one case and on the last tap in the other. A scoreboard then checks the exact read sequence and counts overrun pulses. One drop is expected in the first case and none in the second. A base-pointer write made during a walk is also checked: it must apply only from the next output.

// File: rtl/coef_seq_pkg.sv
package coef_seq_pkg;

    localparam int MEM_AW  = 8;
    localparam int DEC_W   = 8;
    localparam int COEF_W  = 16;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DECIM  = 3'd0,
        SEL_TAPS   = 3'd1,
        SEL_PHASE  = 3'd2,
        SEL_OFFSET = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic bank_hi;
        logic nbr_src;
        logic bypass;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cs_regs.sv
module cs_regs
    import coef_seq_pkg::*;
#(
    parameter int AW = MEM_AW,
    parameter int DW = DEC_W,
    parameter int WW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [WW-1:0]    wdata,
    output logic [DW-1:0]    decim_m1,
    output logic [AW-1:0]    taps_m1,
    output logic [DW-1:0]    phase,
    output logic [AW-1:0]    shadow_off,
    output ctrl_t            ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            decim_m1   <= '0;
            taps_m1    <= '0;
            phase      <= '0;
            shadow_off <= '0;
            ctrl       <= '0;
        end else if (we) begin
            case (reg_sel_e'(sel))
                SEL_DECIM:  decim_m1   <= wdata[DW-1:0];
                SEL_TAPS:   taps_m1    <= wdata[AW-1:0];
                SEL_PHASE:  phase      <= wdata[DW-1:0];
                SEL_OFFSET: shadow_off <= wdata[AW-1:0];
                SEL_CTRL:   ctrl       <= ctrl_t'(wdata[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cs_decim_cnt.sv
module cs_decim_cnt
    import coef_seq_pkg::*;
#(
    parameter int DW = DEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sample,
    input  logic [DW-1:0] phase,
    input  logic [DW-1:0] decim_m1,
    output logic          fire
);
    logic [DW-1:0] cnt;
    logic          running;
    logic          hit;

    assign hit  = (cnt >= decim_m1);
    assign fire = running && sample && !start && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= phase;
            running <= 1'b1;
        end else if (running && sample) begin
            cnt <= hit ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cs_tap_walk.sv
module cs_tap_walk
    import coef_seq_pkg::*;
#(
    parameter int AW = MEM_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW-1:0] shadow_off,
    input  logic [AW-1:0] taps_m1,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic          first_tap,
    output logic          last_tap,
    output logic          overrun
);
    logic          busy;
    logic [AW-1:0] idx;
    logic [AW-1:0] base;
    logic          at_last;
    logic          accept;

    assign at_last = busy && (idx == taps_m1);
    assign accept  = req && (!busy || at_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            base    <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= req && busy && !at_last;
            if (accept) begin
                busy <= 1'b1;
                idx  <= '0;
                base <= shadow_off;
            end else if (busy) begin
                if (at_last) busy <= 1'b0;
                idx <= idx + 1'b1;
            end
        end
    end

    assign rd_valid  = busy;
    assign rd_addr   = base + idx;
    assign first_tap = busy && (idx == '0);
    assign last_tap  = at_last;
endmodule

// File: rtl/coef_addr_seq.sv
module coef_addr_seq
    import coef_seq_pkg::*;
#(
    parameter int AW = MEM_AW,
    parameter int DW = DEC_W,
    parameter int CW = COEF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [7:0]       reg_wdata,
    input  logic             start,
    input  logic             own_valid,
    input  logic             nbr_valid,
    input  logic             cw_we,
    input  logic [AW-2:0]    cw_addr,
    input  logic [CW-1:0]    cw_data,
    output logic             rd_valid,
    output logic [AW-1:0]    rd_addr,
    output logic             first_tap,
    output logic             last_tap,
    output logic             overrun,
    output logic             byp_valid,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [CW-1:0]    mem_wdata
);
    localparam int WW = 8;

    logic [DW-1:0] decim_m1;
    logic [AW-1:0] taps_m1;
    logic [DW-1:0] phase;
    logic [AW-1:0] shadow_off;
    ctrl_t         ctrl;
    logic          sel_valid;
    logic          samp_fire;

    cs_regs #(.AW(AW), .DW(DW), .WW(WW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .decim_m1   (decim_m1),
        .taps_m1    (taps_m1),
        .phase      (phase),
        .shadow_off (shadow_off),
        .ctrl       (ctrl)
    );

    assign sel_valid = ctrl.nbr_src ? nbr_valid : own_valid;
    assign byp_valid = ctrl.bypass && sel_valid;

    cs_decim_cnt #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sample   (sel_valid && !ctrl.bypass),
        .phase    (phase),
        .decim_m1 (decim_m1),
        .fire     (samp_fire)
    );

    cs_tap_walk #(.AW(AW)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .req        (samp_fire),
        .shadow_off (shadow_off),
        .taps_m1    (taps_m1),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr),
        .first_tap  (first_tap),
        .last_tap   (last_tap),
        .overrun    (overrun)
    );

    assign mem_we    = cw_we;
    assign mem_waddr = {ctrl.bank_hi, cw_addr};
    assign mem_wdata = cw_data;
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_valid,
    input logic [AW-1:0] rd_addr,
    input logic          first_tap,
    input logic          last_tap,
    input logic          overrun,
    input logic          fire,
    input logic          bypass,
    input logic          bank,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr
);
    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !last_tap |=> rd_valid && !first_tap && rd_addr == $past(rd_addr) + 1'b1);

    a_r6_after_last: assert property (@(posedge clk) disable iff (rst)
        rd_valid && last_tap |=> !rd_valid || first_tap);

    a_r8_overrun_mid_walk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(rd_valid) && !$past(last_tap));

    a_r9_bypass_no_fire: assert property (@(posedge clk) disable iff (rst)
        bypass |-> !fire);

    a_r11_low_half: assert property (@(posedge clk) disable iff (rst)
        mem_we && !bank |-> !mem_waddr[AW-1]);
endmodule

bind coef_addr_seq cs_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .first_tap (first_tap),
    .last_tap  (last_tap),
    .overrun   (overrun),
    .fire      (samp_fire),
    .bypass    (ctrl.bypass),
    .bank      (ctrl.bank_hi),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr)
);

// File: tb/coef_addr_seq_test.sv
`timescale 1ns/1ps
module coef_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic        start, own_valid, nbr_valid;
    logic        cw_we;
    logic [6:0]  cw_addr;
    logic [15:0] cw_data;
    logic        rd_valid, first_tap, last_tap, overrun, byp_valid, mem_we;
    logic [7:0]  rd_addr, mem_waddr;
    logic [15:0] mem_wdata;

    always #4 clk = ~clk;

    coef_addr_seq uut (.*);

    typedef struct { logic [7:0] a; logic f; logic l; string r; } exp_t;
    exp_t q[$];

    int n_chk = 0, n_bad = 0, ovr_seen = 0;
    int m_dm1 = 0, m_taps = 0, m_phase = 0, m_off = 0, m_cnt = 0;
    bit m_run = 0, m_byp = 0, m_nbr = 0, m_bank = 0, suppress = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input int sel, input int data);
        reg_we = 1; reg_sel = sel[2:0]; reg_wdata = data[7:0];
        case (sel)
            0: m_dm1 = data;
            1: m_taps = data;
            2: m_phase = data;
            3: m_off = data;
            4: begin m_byp = data[0]; m_nbr = data[1]; m_bank = data[2]; end
            default: ;
        endcase
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic do_start();
        start = 1; m_cnt = m_phase; m_run = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic push_out(input string req);
        for (int i = 0; i <= m_taps; i++) begin
            exp_t e;
            e.a = 8'((m_off + i) % 256);
            e.f = (i == 0);
            e.l = (i == m_taps);
            e.r = req;
            q.push_back(e);
        end
    endtask

    task automatic sample(input bit own, input bit nbr, input int idle, input string req);
        bit counted;
        own_valid = own; nbr_valid = nbr;
        counted = m_run && !m_byp && (m_nbr ? nbr : own);
        if (counted) begin
            if (m_cnt >= m_dm1) begin
                m_cnt = 0;
                if (!suppress) push_out(req);
            end else m_cnt++;
        end
        if (m_byp) begin
            #1 check(byp_valid == (m_nbr ? nbr : own), "R9", "byp_valid",
                     byp_valid, m_nbr ? nbr : own);
        end
        @(negedge clk);
        own_valid = 0; nbr_valid = 0;
        repeat (idle) @(negedge clk);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 600; i++) begin
            if (q.size() == 0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check(q.size() == 0, req, "reads outstanding", q.size(), 0);
    endtask

    // monitor: pops expected reads as the design issues them
    always @(negedge clk) begin
        if (!rst) begin
            if (overrun) ovr_seen++;
            if (rd_valid) begin
                if (q.size() == 0) begin
                    check(0, "R4", "unexpected read", {rd_addr, first_tap, last_tap}, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rd_addr == e.a && first_tap == e.f && last_tap == e.l, e.r,
                          "read {addr,first,last}", {rd_addr, first_tap, last_tap},
                          {e.a, e.f, e.l});
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int o0;
        rst = 1; reg_we = 0; reg_sel = 0; reg_wdata = 0; start = 0;
        own_valid = 0; nbr_valid = 0; cw_we = 0; cw_addr = 0; cw_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check(!rd_valid && !first_tap && !last_tap && !overrun, "R1", "reset outputs",
              {rd_valid, first_tap, last_tap, overrun}, 0);
        // R1: no counting before start
        wr_reg(0, 0);
        sample(1, 0, 3, "R1");
        drain("R1");

        // R11: coefficient writes, low and high half
        cw_we = 1; cw_addr = 7'h05; cw_data = 16'hBEEF;
        #1 check(mem_we && mem_waddr == 8'h05 && mem_wdata == 16'hBEEF, "R11", "low half",
                 {mem_we, mem_waddr, mem_wdata}, {1'b1, 8'h05, 16'hBEEF});
        @(negedge clk); cw_we = 0;
        wr_reg(4, 4);
        cw_we = 1; cw_addr = 7'h7F; cw_data = 16'h1234;
        #1 check(mem_we && mem_waddr == 8'hFF && mem_wdata == 16'h1234, "R11", "high half",
                 {mem_we, mem_waddr, mem_wdata}, {1'b1, 8'hFF, 16'h1234});
        @(negedge clk); cw_we = 0;
        wr_reg(4, 0);

        // R2 R4 R5: M=4, N=3, base 0x10
        wr_reg(0, 3); wr_reg(1, 2); wr_reg(2, 0); wr_reg(3, 8'h10);
        do_start();
        for (int k = 0; k < 8; k++) sample(1, 0, 4, "R2");
        drain("R2");

        // R3: phase 2 -> first output after 2 samples
        wr_reg(2, 2);
        do_start();
        for (int k = 0; k < 6; k++) sample(1, 0, 4, "R3");
        drain("R3");
        // R3: phase write without start has no effect
        wr_reg(2, 3);
        for (int k = 0; k < 4; k++) sample(1, 0, 4, "R3");
        drain("R3");
        do_start();
        sample(1, 0, 4, "R3");
        drain("R3");

        // R5: wrap modulo 256
        wr_reg(0, 0); wr_reg(2, 0); wr_reg(1, 3); wr_reg(3, 8'hFE);
        do_start();
        sample(1, 0, 0, "R5");
        drain("R5");

        // R7: base write mid-walk only affects the next output
        wr_reg(1, 7); wr_reg(3, 8'h40);
        sample(1, 0, 1, "R7");
        wr_reg(3, 8'h80);
        o0 = m_off;
        drain("R7");
        sample(1, 0, 0, "R7");
        drain("R7");
        check(o0 == 8'h80, "R7", "model base", o0, 8'h80);

        // R8: request mid-walk dropped, overrun pulse
        wr_reg(1, 3); wr_reg(3, 8'h20);
        ovr_seen = 0;
        sample(1, 0, 0, "R8");
        suppress = 1;
        sample(1, 0, 0, "R8");
        suppress = 0;
        drain("R8");
        check(ovr_seen == 1, "R8", "overrun pulses", ovr_seen, 1);
        // R8: request on last tap continues without gap or overrun
        wr_reg(1, 1);
        ovr_seen = 0;
        sample(1, 0, 1, "R8");
        sample(1, 0, 1, "R8");
        sample(1, 0, 1, "R8");
        drain("R8");
        check(ovr_seen == 0, "R8", "overrun on last tap", ovr_seen, 0);

        // R6: single tap, every cycle
        wr_reg(1, 0); wr_reg(3, 8'h33);
        ovr_seen = 0;
        for (int k = 0; k < 3; k++) sample(1, 0, 0, "R6");
        drain("R6");
        check(ovr_seen == 0, "R6", "overrun single tap", ovr_seen, 0);

        // R9: bypass
        wr_reg(4, 1);
        sample(1, 0, 0, "R9");
        sample(0, 1, 0, "R9");
        sample(1, 0, 2, "R9");
        drain("R9");
        wr_reg(4, 0);
        #1 check(byp_valid == 0, "R9", "byp_valid off", byp_valid, 0);

        // R10: neighbour source select
        wr_reg(0, 1); wr_reg(1, 2); wr_reg(3, 8'h50); wr_reg(4, 2);
        do_start();
        sample(1, 0, 2, "R10");
        sample(1, 0, 2, "R10");
        drain("R10");
        sample(0, 1, 2, "R10");
        sample(0, 1, 2, "R10");
        drain("R10");
        wr_reg(4, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule